// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block is the front end for 28 external interrupt pins. Each pin is brought into the clock domain through a two-stage synchroniser. It is then tested against a programmable trigger condition: low level, high level, falling edge, rising edge or both edges. A detection sets the line's pending bit, which stays set until software clears it.

A mask bit per line decides whether a pending line takes part in its group. The active lines are reduced onto four group request outputs of unequal size, which feed a parent vectored interrupt controller. Software reaches the block through a small register port. The port gives access to:

- two trigger configuration words, in which adjacent lines share one 3-bit field;
- the mask word;
- a pending word that is cleared by writing ones.

Top module: `eint_group_ctrl`

## Requirements
- R1: After reset the configuration words read 0x77777777 (address 0) and 0x00777777 (address 1). All trigger fields are 3'b111, which disables detection. The mask word reads 0x0FFFFFFF (every line blocked), the pending word reads 0 and all four group outputs are low.
- R2: The register port uses a 2-bit address: 0 holds the trigger fields for lines 0 to 15, 1 holds those for lines 16 to 27, 2 is the mask and 3 is pending. Reads are combinational from the address. A write takes effect at the clock edge where both `bus_en` and `bus_we` are high. In the mask and pending words, bit n is line n. Bits 31:28 read 0 and writes to them are ignored.
- R3: Lines 2k and 2k+1 share one trigger field. For lines 0 to 15 the field is bits [(n/2)*4 +: 3] of address 0. For lines 16 to 27 it is bits [((n-16)/2)*4 +: 3] of address 1. Bit 3 of every nibble, and bits 31:24 of address 1, read 0.
- R4: Trigger codes are 000 low level, 001 high level, 010 falling edge, 100 rising edge and 110 both edges. Every other code disables detection on both lines of the pair.
- R5: Suppose a pin changes before rising edge k. Its pending bit is then still clear after edge k+1 and is set after edge k+2. This latency comes from two synchroniser stages plus the detection register.
- R6: Writing to address 3 clears every pending bit written with 1 and leaves every bit written with 0 unchanged. A pending write never sets a bit.
- R7: A level trigger sets its pending bit again on every cycle the level is present. If a detection and a clear hit the same bit in the same cycle, the bit stays set.
- R8: A mask bit of 1 keeps its line out of its group output. The pending bit still latches while the line is masked.
- R9: `irq_grp[0]` covers lines 0 to 3, `irq_grp[1]` lines 4 to 11, `irq_grp[2]` lines 12 to 19 and `irq_grp[3]` lines 20 to 27. Each output is high while any line in its range is both pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pins | input | 28 | Asynchronous external interrupt pins, bit n is line n |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | 2 | Register select (0 cfg low, 1 cfg high, 2 mask, 3 pending) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_grp | output | 4 | Group requests to the parent controller |

## Verification
The assertions are checked on every cycle:

- A detection always lands in the pending word, even when a clear is written in the same cycle.
- Pending bits never drop without a write of ones.
- A pending write clears exactly the written bits that had no detection.
- Mask writes land in the mask word.
- The group outputs stay low when nothing is pending or everything is masked, and rise whenever some unmasked line is pending.

Only the bench scenarios can show the rest:

- the two-edge detection latency;
- the meaning of each trigger code;
- the sharing of one field by two lines;
- the exact placement of group boundaries.

The bench shows these with directed pin sequences and a reference model that runs alongside random traffic.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int NUM_LINES    = 28;
    localparam int LO_LINES     = 16;
    localparam int DATA_W       = 32;
    localparam int FIELD_W      = 3;
    localparam int FIELD_STRIDE = 4;
    localparam int NUM_GROUPS   = 4;
    localparam int ADDR_W       = 2;

    // Trigger codes; anything else disables detection.
    typedef enum logic [FIELD_W-1:0] {
        TRIG_LOW  = 3'b000,
        TRIG_HIGH = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_RISE = 3'b100,
        TRIG_BOTH = 3'b110
    } trig_e;

    localparam logic [FIELD_W-1:0] TRIG_OFF = 3'b111;

    localparam logic [ADDR_W-1:0] ADDR_CFG_LO = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG_HI = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_PEND   = 2'd3;

    // Group 0 holds four lines, every later group eight.
    function automatic int group_first(input int g);
        return (g == 0) ? 0 : 4 + 8 * (g - 1);
    endfunction

    function automatic int group_last(input int g);
        return 3 + 8 * g;
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pins;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.s2;
    assign lvl_prev = st_q.prev;

endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int N  = 28,
    localparam int NF = N / 2
) (
    input  logic [N-1:0]              lvl,
    input  logic [N-1:0]              lvl_prev,
    input  logic [NF-1:0][FIELD_W-1:0] trig,
    output logic [N-1:0]              det
);

    for (genvar i = 0; i < N; i++) begin : g_line
        always_comb begin
            case (trig_e'(trig[i/2]))
                TRIG_LOW:  det[i] = ~lvl[i];
                TRIG_HIGH: det[i] =  lvl[i];
                TRIG_FALL: det[i] = ~lvl[i] &  lvl_prev[i];
                TRIG_RISE: det[i] =  lvl[i] & ~lvl_prev[i];
                TRIG_BOTH: det[i] =  lvl[i] ^  lvl_prev[i];
                default:   det[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int N  = 28,
    parameter int NL = 16,
    localparam int NF    = N / 2,
    localparam int NF_LO = NL / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [N-1:0]                det,
    output logic [NF-1:0][FIELD_W-1:0]  trig,
    output logic [N-1:0]                mask,
    output logic [N-1:0]                pend
);

    typedef struct packed {
        logic [NF-1:0][FIELD_W-1:0] trig;
        logic [N-1:0]               mask;
        logic [N-1:0]               pend;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr;
    logic  [N-1:0] clr;
    logic  unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr = bus_en & bus_we;

    always_comb begin
        rg_d = rg_q;
        clr  = '0;
        if (wr) begin
            case (bus_addr)
                ADDR_CFG_LO: begin
                    for (int k = 0; k < NF_LO; k++)
                        rg_d.trig[k] = bus_wdata[k*FIELD_STRIDE +: FIELD_W];
                end
                ADDR_CFG_HI: begin
                    for (int k = NF_LO; k < NF; k++)
                        rg_d.trig[k] = bus_wdata[(k-NF_LO)*FIELD_STRIDE +: FIELD_W];
                end
                ADDR_MASK: rg_d.mask = bus_wdata[N-1:0];
                default:   clr = bus_wdata[N-1:0];
            endcase
        end
        // a detection in the same cycle outranks a clear
        rg_d.pend = (rg_q.pend & ~clr) | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.trig <= {NF{TRIG_OFF}};
            rg_q.mask <= '1;
            rg_q.pend <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CFG_LO: begin
                for (int k = 0; k < NF_LO; k++)
                    bus_rdata[k*FIELD_STRIDE +: FIELD_W] = rg_q.trig[k];
            end
            ADDR_CFG_HI: begin
                for (int k = NF_LO; k < NF; k++)
                    bus_rdata[(k-NF_LO)*FIELD_STRIDE +: FIELD_W] = rg_q.trig[k];
            end
            ADDR_MASK: bus_rdata[N-1:0] = rg_q.mask;
            default:   bus_rdata[N-1:0] = rg_q.pend;
        endcase
    end

    assign trig = rg_q.trig;
    assign mask = rg_q.mask;
    assign pend = rg_q.pend;

endmodule

// File: rtl/eint_group.sv
module eint_group
    import eint_pkg::*;
#(
    parameter int N = 28,
    parameter int G = 4
) (
    input  logic [N-1:0] act,
    output logic [G-1:0] grp
);

    for (genvar g = 0; g < G; g++) begin : g_grp
        localparam int FIRST = group_first(g);
        localparam int LAST  = group_last(g);
        assign grp[g] = |act[LAST:FIRST];
    end

endmodule

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl
    import eint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  ext_pins,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_GROUPS-1:0] irq_grp
);

    localparam int NF = NUM_LINES / 2;

    logic [NUM_LINES-1:0]        lvl_vec, prev_vec, det_vec, mask_vec, pend_vec, act_vec;
    logic [NF-1:0][FIELD_W-1:0]  trig_vec;

    eint_sync #(.W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (ext_pins),
        .lvl      (lvl_vec),
        .lvl_prev (prev_vec)
    );

    eint_detect #(.N(NUM_LINES)) u_detect (
        .lvl      (lvl_vec),
        .lvl_prev (prev_vec),
        .trig     (trig_vec),
        .det      (det_vec)
    );

    eint_regs #(.N(NUM_LINES), .NL(LO_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .det       (det_vec),
        .trig      (trig_vec),
        .mask      (mask_vec),
        .pend      (pend_vec)
    );

    assign act_vec = pend_vec & ~mask_vec;

    eint_group #(.N(NUM_LINES), .G(NUM_GROUPS)) u_group (
        .act (act_vec),
        .grp (irq_grp)
    );

endmodule

// File: rtl/eint_group_ctrl_chk.sv
module eint_group_ctrl_chk
    import eint_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_en,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [NUM_LINES-1:0]  wdata,
    input logic [NUM_LINES-1:0]  det,
    input logic [NUM_LINES-1:0]  mask,
    input logic [NUM_LINES-1:0]  pend,
    input logic [NUM_GROUPS-1:0] grp
);

    logic pend_wr, mask_wr;
    assign pend_wr = bus_en && bus_we && (bus_addr == ADDR_PEND);
    assign mask_wr = bus_en && bus_we && (bus_addr == ADDR_MASK);

    // R7
    det_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det != '0) |=> ((pend & $past(det)) == $past(det)));

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend & $past(wdata) & ~$past(det)) == '0));

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> ((~pend & $past(pend)) == '0));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wdata)));

    // R8
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> (grp == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (grp == '0));

    // R9
    active_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) != '0) |-> (grp != '0));

endmodule

bind eint_group_ctrl eint_group_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wdata    (bus_wdata[eint_pkg::NUM_LINES-1:0]),
    .det      (det_vec),
    .mask     (mask_vec),
    .pend     (pend_vec),
    .grp      (irq_grp)
);

// File: tb/eint_group_ctrl_test.sv
module eint_group_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] ext_pins = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eint_group_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_pins(ext_pins),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_grp(irq_grp)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [27:0] m_s1, m_s2, m_prev, m_mask, m_pend;
    logic [2:0]  m_trig [14];

    function automatic logic fdet(input logic [2:0] f, input logic s, input logic p);
        case (f)
            3'b000:  return ~s;
            3'b001:  return s;
            3'b010:  return ~s & p;
            3'b100:  return s & ~p;
            3'b110:  return s ^ p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        logic [31:0] r = '0;
        case (a)
            2'd0: for (int k = 0; k < 8; k++) r[k*4 +: 3] = m_trig[k];
            2'd1: for (int k = 0; k < 6; k++) r[k*4 +: 3] = m_trig[8+k];
            2'd2: r[27:0] = m_mask;
            default: r[27:0] = m_pend;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] m_grp();
        logic [27:0] a = m_pend & ~m_mask;
        return {|a[27:20], |a[19:12], |a[11:4], |a[3:0]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_mask <= '1; m_pend <= '0;
            for (int k = 0; k < 14; k++) m_trig[k] <= 3'b111;
        end else begin
            logic [27:0] det, clr;
            det = '0;
            clr = '0;
            for (int i = 0; i < 28; i++) det[i] = fdet(m_trig[i/2], m_s2[i], m_prev[i]);
            if (bus_en && bus_we) begin
                case (bus_addr)
                    2'd0: for (int k = 0; k < 8; k++) m_trig[k] <= bus_wdata[k*4 +: 3];
                    2'd1: for (int k = 0; k < 6; k++) m_trig[8+k] <= bus_wdata[k*4 +: 3];
                    2'd2: m_mask <= bus_wdata[27:0];
                    default: clr = bus_wdata[27:0];
                endcase
            end
            m_pend <= (m_pend & ~clr) | det;
            m_s1 <= ext_pins;
            m_s2 <= m_s1;
            m_prev <= m_s2;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R5 progress): actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int unsigned seed = 32'd24680;
        void'($urandom(seed));

        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 cfg lo reset", v, 32'h7777_7777);
        rd(2'd1, v); chk("R1 cfg hi reset", v, 32'h0077_7777);
        rd(2'd2, v); chk("R1 mask reset", v, 32'h0FFF_FFFF);
        rd(2'd3, v); chk("R1 pending reset", v, 32'h0);
        chk("R1 groups reset", {28'h0, irq_grp}, 32'h0);

        // R2/R3 reserved bits stay zero
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R3 cfg lo reserved bits", v, 32'h7777_7777);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R3 cfg hi reserved bits", v, 32'h0077_7777);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R2 mask upper bits", v, 32'h0FFF_FFFF);

        // R5 latency with a rising trigger on line 0
        wr(2'd0, 32'h7777_7774);
        wr(2'd2, 32'h0FFF_FFFE);
        ext_pins[0] = 1'b1;
        tick(2); rd(2'd3, v); chk("R5 not yet pending", v, 32'h0);
        tick(1); rd(2'd3, v); chk("R5 pending after third edge", v, 32'h1);
        chk("R9 group0 for line 0", {28'h0, irq_grp}, 32'h1);

        // R6 write-one-to-clear
        wr(2'd3, 32'h0); rd(2'd3, v); chk("R6 zero write keeps bit", v, 32'h1);
        wr(2'd3, 32'h1); rd(2'd3, v); chk("R6 one write clears bit", v, 32'h0);
        chk("R6 group drops after clear", {28'h0, irq_grp}, 32'h0);
        ext_pins[0] = 1'b0;
        tick(4); rd(2'd3, v); chk("R4 rising ignores fall", v, 32'h0);

        // R7 high level on line 5, clear while asserted
        wr(2'd0, 32'h7777_7174);
        wr(2'd2, 32'h0FFF_FFCE);
        ext_pins[5] = 1'b1;
        tick(3); rd(2'd3, v); chk("R4 high level detect", v, 32'h20);
        chk("R9 group1 for line 5", {28'h0, irq_grp}, 32'h2);
        wr(2'd3, 32'h20); rd(2'd3, v); chk("R7 detection beats clear", v, 32'h20);
        // R3 line 4 shares the field of line 5
        ext_pins[4] = 1'b1;
        tick(3); rd(2'd3, v); chk("R3 shared field line 4", v, 32'h30);
        // R8 masked line still latches, group stays low
        wr(2'd2, 32'h0FFF_FFFF);
        chk("R8 masked group low", {28'h0, irq_grp}, 32'h0);
        rd(2'd3, v); chk("R8 pending kept while masked", v, 32'h30);
        ext_pins[4] = 1'b0; ext_pins[5] = 1'b0;
        tick(3);
        wr(2'd3, 32'h30); rd(2'd3, v); chk("R7 clear after level gone", v, 32'h0);

        // R4 falling edge on line 12
        wr(2'd0, 32'h7277_7174);
        wr(2'd2, 32'h0FFF_EFFF);
        ext_pins[12] = 1'b1;
        tick(3); rd(2'd3, v); chk("R4 falling ignores rise", v, 32'h0);
        ext_pins[12] = 1'b0;
        tick(3); rd(2'd3, v); chk("R4 falling detect", v, 32'h1000);
        chk("R9 group2 for line 12", {28'h0, irq_grp}, 32'h4);
        wr(2'd3, 32'h1000);

        // R4 both edges on line 20
        wr(2'd1, 32'h0077_7677);
        wr(2'd2, 32'h0FEF_FFFF);
        ext_pins[20] = 1'b1;
        tick(3); rd(2'd3, v); chk("R4 both edges rise", v, 32'h0010_0000);
        chk("R9 group3 for line 20", {28'h0, irq_grp}, 32'h8);
        wr(2'd3, 32'h0010_0000);
        ext_pins[20] = 1'b0;
        tick(3); rd(2'd3, v); chk("R4 both edges fall", v, 32'h0010_0000);
        wr(2'd3, 32'h0010_0000);

        // R4 unlisted code disables lines 26 and 27
        wr(2'd1, 32'h0037_7677);
        ext_pins[26] = 1'b1; tick(3);
        ext_pins[26] = 1'b0; tick(3);
        rd(2'd3, v); chk("R4 disabled code", v, 32'h0);

        // R4 low level on lines 24/25 with pins low
        wr(2'd1, 32'h0030_7677);
        tick(3); rd(2'd3, v); chk("R4 low level detect", v, 32'h0300_0000);
        ext_pins[25:24] = 2'b11;
        tick(3);
        wr(2'd3, 32'h0300_0000); rd(2'd3, v); chk("R6 clear low-level pair", v, 32'h0);

        // random traffic against the model (R2, R9)
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] exp_rd;
            exp_rd = m_read(bus_addr);
            chk("R2 random read", bus_rdata, exp_rd);
            chk("R9 random groups", {28'h0, irq_grp}, {28'h0, m_grp()});
            if (($urandom % 4) == 0) ext_pins[$urandom % 28] ^= 1'b1;
            bus_addr = 2'($urandom % 4);
            if (($urandom % 6) == 0) begin
                bus_en = 1'b1; bus_we = 1'b1; bus_wdata = $urandom;
            end else begin
                bus_en = 1'b0; bus_we = 1'b0;
            end
            @(negedge clk);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule